// File: doc/BRIEF.md
# Transceiver Loopback and Timing Mode Controller

This block decides where every datapath mux of a serializer/deserializer pair takes its input from. It looks at the loopback controls (line-side loopback, host-side loopback, loopback into the clock-recovery input), the two loop-timing controls, the clock-recovery bypass and the loss-of-signal state. From these it produces one registered source tag for each destination: serial transmit data, serial transmit clock, clock-recovery input, deserializer input, parallel receive data, parallel receive clock and clock-multiplier reference. The serializer, deserializer and PLLs are not modelled. They appear only as source tags, so the routing can be observed directly.

New selects are computed all the time, but the output registers load them only on a cycle where `update_i` is high. The datapath muxes therefore switch once, at a known edge. Both loopbacks may be active together (split mode). Reference-from-receive loop timing is suppressed automatically whenever loss of signal or host-side loopback is present, so the multiplier can never be referenced to its own output.

Top module: `xmc_mode_ctrl`

## Requirements

Tag codes used by every output: 0 serializer output, 1 serial input pin, 2 recovered line data, 3 external line data, 4 deserializer output, 5 parallel transmit bus, 6 synthesized clock, 7 recovered receive clock, 8 external receive clock, 9 synthesized clock divided by 8, 10 receive clock divided by 8, 11 parallel transmit byte clock, 12 reference clock pin.

- R1: Reset state of the outputs, which is also the result with all controls low: serial data 0, serial clock 6, recovery input 1, deserializer input 2, parallel data 4, parallel clock 10, reference 12.
- R2: An output register loads only at a rising edge where `update_i` is high, and the new value appears right after that edge. When `update_i` is low, all outputs hold, whatever the controls do.
- R3: With line-side loopback on and host-side loopback off, serial data is the receive data (2, or 3 when bypassed) and serial clock is the receive clock (7, or 8 when bypassed). The deserializer input is still the receive data and parallel data is 4.
- R4: With host-side loopback on and line-side off, the deserializer input is 0 and the parallel clock is 9. Serial data stays 0 and serial clock stays 6.
- R5: With both loopbacks on (split), serial data and clock are the receive data and clock, parallel data is 5 and parallel clock is 11.
- R6: With recovery-input loopback on, the recovery input is 0; otherwise it is 1.
- R7: With the bypass on, receive data is 3 and receive clock is 8 wherever they are routed; otherwise they are 2 and 7.
- R8: Loop timing 0 replaces the synthesized clock by the receive clock everywhere: serial clock 7/8 instead of 6, and parallel clock 10 instead of 9 in host-side loopback.
- R9: Loop timing 1 alone sets the reference to 10; otherwise it is 12.
- R10: Loop timing 1 is overridden (reference 12) while loss of signal or host-side loopback is present, split mode included.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| update_i | input | 1 | Load the computed selects at this edge |
| fac_loop_i | input | 1 | Line-side loopback |
| eq_loop_i | input | 1 | Host-side loopback |
| cru_eq_loop_i | input | 1 | Serializer output into clock-recovery input |
| loop_time0_i | input | 1 | Receive clock replaces synthesized clock |
| loop_time1_i | input | 1 | Receive clock /8 as multiplier reference |
| cru_bypass_i | input | 1 | Use external receive clock and data |
| los_i | input | 1 | Loss-of-signal state |
| ser_data_src_o | output | 4 | Source of serial transmit data |
| ser_clk_src_o | output | 4 | Source of serial transmit clock |
| cru_in_src_o | output | 4 | Source at clock-recovery input |
| des_in_src_o | output | 4 | Source at deserializer input |
| par_data_src_o | output | 4 | Source of parallel receive data |
| par_clk_src_o | output | 4 | Source of parallel receive clock |
| pll_ref_src_o | output | 4 | Source of multiplier reference |

## Verification

Every output has exactly one register between the controls and the port. A setting sampled with `update_i` high at one rising edge is therefore due right after that edge. The bench drives controls and `update_i` on the falling edge and reads all seven tags at the next falling edge. For the hold rule, it changes the controls with `update_i` low and re-reads over several cycles. It also reads once more with `update_i` high but before the loading edge, to show the old value is still present until that edge.

// File: rtl/xmc_pkg.sv
package xmc_pkg;
  localparam int TAG_W   = 4;
  localparam int NUM_SEL = 7;

  localparam int SEL_SER_DATA = 0;
  localparam int SEL_SER_CLK  = 1;
  localparam int SEL_CRU_IN   = 2;
  localparam int SEL_DES_IN   = 3;
  localparam int SEL_PAR_DATA = 4;
  localparam int SEL_PAR_CLK  = 5;
  localparam int SEL_PLL_REF  = 6;

  typedef enum logic [TAG_W-1:0] {
    T_SER_OUT    = 4'd0,
    T_LINE_PIN   = 4'd1,
    T_LINE_REC   = 4'd2,
    T_LINE_EXT   = 4'd3,
    T_DESER      = 4'd4,
    T_TX_BUS     = 4'd5,
    T_CLK_SYN    = 4'd6,
    T_CLK_RX_REC = 4'd7,
    T_CLK_RX_EXT = 4'd8,
    T_CLK_SYN_D8 = 4'd9,
    T_CLK_RX_D8  = 4'd10,
    T_CLK_TX_BYT = 4'd11,
    T_CLK_REFPIN = 4'd12
  } tag_e;

  function automatic logic [TAG_W-1:0] reset_tag(int idx);
    case (idx)
      SEL_SER_DATA: return T_SER_OUT;
      SEL_SER_CLK:  return T_CLK_SYN;
      SEL_CRU_IN:   return T_LINE_PIN;
      SEL_DES_IN:   return T_LINE_REC;
      SEL_PAR_DATA: return T_DESER;
      SEL_PAR_CLK:  return T_CLK_RX_D8;
      default:      return T_CLK_REFPIN;
    endcase
  endfunction
endpackage

// File: rtl/xmc_clk_src.sv
module xmc_clk_src
  import xmc_pkg::*;
(
  input  logic lt0_i,
  input  logic byp_i,
  output tag_e rx_data_o,
  output tag_e rx_clk_o,
  output tag_e syn_clk_o,
  output tag_e syn_div_o
);
  always_comb begin
    rx_data_o = byp_i ? T_LINE_EXT : T_LINE_REC;
    rx_clk_o  = byp_i ? T_CLK_RX_EXT : T_CLK_RX_REC;
    // loop timing 0: receive clock stands in for the synthesizer
    syn_clk_o = lt0_i ? rx_clk_o : T_CLK_SYN;
    syn_div_o = lt0_i ? T_CLK_RX_D8 : T_CLK_SYN_D8;
  end
endmodule

// File: rtl/xmc_tx_route.sv
module xmc_tx_route
  import xmc_pkg::*;
(
  input  logic fac_i,
  input  tag_e rx_data_i,
  input  tag_e rx_clk_i,
  input  tag_e syn_clk_i,
  output tag_e ser_data_o,
  output tag_e ser_clk_o
);
  always_comb begin
    ser_data_o = fac_i ? rx_data_i : T_SER_OUT;
    ser_clk_o  = fac_i ? rx_clk_i  : syn_clk_i;
  end
endmodule

// File: rtl/xmc_rx_route.sv
module xmc_rx_route
  import xmc_pkg::*;
(
  input  logic fac_i,
  input  logic eq_i,
  input  logic cru_eq_i,
  input  tag_e rx_data_i,
  input  tag_e syn_div_i,
  output tag_e cru_in_o,
  output tag_e des_in_o,
  output tag_e par_data_o,
  output tag_e par_clk_o
);
  logic split;
  assign split = fac_i & eq_i;

  always_comb begin
    cru_in_o   = cru_eq_i ? T_SER_OUT : T_LINE_PIN;
    // in split mode the deserializer keeps line data; the byte bus bypasses it
    des_in_o   = (eq_i && !fac_i) ? T_SER_OUT : rx_data_i;
    par_data_o = split ? T_TX_BUS : T_DESER;
    if (split)     par_clk_o = T_CLK_TX_BYT;
    else if (eq_i) par_clk_o = syn_div_i;
    else           par_clk_o = T_CLK_RX_D8;
  end
endmodule

// File: rtl/xmc_ref_guard.sv
module xmc_ref_guard
  import xmc_pkg::*;
(
  input  logic lt1_i,
  input  logic los_i,
  input  logic eq_i,
  output tag_e pll_ref_o
);
  logic lt1_ok;
  // never reference the multiplier to a clock it may itself be driving
  assign lt1_ok    = lt1_i & ~los_i & ~eq_i;
  assign pll_ref_o = lt1_ok ? T_CLK_RX_D8 : T_CLK_REFPIN;
endmodule

// File: rtl/xmc_upd_reg.sv
module xmc_upd_reg #(
  parameter int             W   = 4,
  parameter logic [W-1:0]   RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/xmc_mode_ctrl.sv
module xmc_mode_ctrl
  import xmc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             update_i,
  input  logic             fac_loop_i,
  input  logic             eq_loop_i,
  input  logic             cru_eq_loop_i,
  input  logic             loop_time0_i,
  input  logic             loop_time1_i,
  input  logic             cru_bypass_i,
  input  logic             los_i,
  output logic [TAG_W-1:0] ser_data_src_o,
  output logic [TAG_W-1:0] ser_clk_src_o,
  output logic [TAG_W-1:0] cru_in_src_o,
  output logic [TAG_W-1:0] des_in_src_o,
  output logic [TAG_W-1:0] par_data_src_o,
  output logic [TAG_W-1:0] par_clk_src_o,
  output logic [TAG_W-1:0] pll_ref_src_o
);
  tag_e rx_data, rx_clk, syn_clk, syn_div;
  tag_e nxt [NUM_SEL];
  logic [TAG_W-1:0] sel_q [NUM_SEL];

  xmc_clk_src u_clk_src (
    .lt0_i     (loop_time0_i),
    .byp_i     (cru_bypass_i),
    .rx_data_o (rx_data),
    .rx_clk_o  (rx_clk),
    .syn_clk_o (syn_clk),
    .syn_div_o (syn_div)
  );

  xmc_tx_route u_tx_route (
    .fac_i      (fac_loop_i),
    .rx_data_i  (rx_data),
    .rx_clk_i   (rx_clk),
    .syn_clk_i  (syn_clk),
    .ser_data_o (nxt[SEL_SER_DATA]),
    .ser_clk_o  (nxt[SEL_SER_CLK])
  );

  xmc_rx_route u_rx_route (
    .fac_i      (fac_loop_i),
    .eq_i       (eq_loop_i),
    .cru_eq_i   (cru_eq_loop_i),
    .rx_data_i  (rx_data),
    .syn_div_i  (syn_div),
    .cru_in_o   (nxt[SEL_CRU_IN]),
    .des_in_o   (nxt[SEL_DES_IN]),
    .par_data_o (nxt[SEL_PAR_DATA]),
    .par_clk_o  (nxt[SEL_PAR_CLK])
  );

  xmc_ref_guard u_ref_guard (
    .lt1_i     (loop_time1_i),
    .los_i     (los_i),
    .eq_i      (eq_loop_i),
    .pll_ref_o (nxt[SEL_PLL_REF])
  );

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    xmc_upd_reg #(
      .W   (TAG_W),
      .RST (reset_tag(g))
    ) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (update_i),
      .d_i    (nxt[g]),
      .q_o    (sel_q[g])
    );
  end

  assign ser_data_src_o = sel_q[SEL_SER_DATA];
  assign ser_clk_src_o  = sel_q[SEL_SER_CLK];
  assign cru_in_src_o   = sel_q[SEL_CRU_IN];
  assign des_in_src_o   = sel_q[SEL_DES_IN];
  assign par_data_src_o = sel_q[SEL_PAR_DATA];
  assign par_clk_src_o  = sel_q[SEL_PAR_CLK];
  assign pll_ref_src_o  = sel_q[SEL_PLL_REF];

  AST_HOLD_SER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> $stable(ser_data_src_o) && $stable(ser_clk_src_o)); // R2
  AST_HOLD_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> $stable(des_in_src_o) && $stable(par_clk_src_o) && $stable(pll_ref_src_o)); // R2
  AST_FAC_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i && fac_loop_i |=> ser_data_src_o inside {T_LINE_REC, T_LINE_EXT}); // R3
  AST_EQ_DES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i && eq_loop_i && !fac_loop_i |=> des_in_src_o == T_SER_OUT); // R4
  AST_SPLIT_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i && eq_loop_i && fac_loop_i |=> par_data_src_o == T_TX_BUS); // R5
  AST_LT0_NO_SYN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i && loop_time0_i |=> ser_clk_src_o != T_CLK_SYN); // R8
  AST_REF_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i && (los_i || eq_loop_i) |=> pll_ref_src_o == T_CLK_REFPIN); // R10
endmodule

// File: tb/xmc_mode_ctrl_bench.sv
module xmc_mode_ctrl_bench;
  localparam int NV = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic update = 1'b0;
  logic [6:0] ctl = '0; // fac, eq, cru_eq, lt0, lt1, byp, los
  logic [3:0] sd, sc, ci, di, pd, pc, pr;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  xmc_mode_ctrl u_xmc_mode_ctrl (
    .clk_i (clk), .rst_ni (rst_ni), .update_i (update),
    .fac_loop_i (ctl[6]), .eq_loop_i (ctl[5]), .cru_eq_loop_i (ctl[4]),
    .loop_time0_i (ctl[3]), .loop_time1_i (ctl[2]), .cru_bypass_i (ctl[1]),
    .los_i (ctl[0]),
    .ser_data_src_o (sd), .ser_clk_src_o (sc), .cru_in_src_o (ci),
    .des_in_src_o (di), .par_data_src_o (pd), .par_clk_src_o (pc),
    .pll_ref_src_o (pr)
  );

  // controls, then expected sd sc ci di pd pc pr
  localparam logic [34:0] VEC [NV] = '{
    {7'b0000000, 4'd0, 4'd6, 4'd1, 4'd2, 4'd4, 4'd10, 4'd12},
    {7'b1000000, 4'd2, 4'd7, 4'd1, 4'd2, 4'd4, 4'd10, 4'd12},
    {7'b1000010, 4'd3, 4'd8, 4'd1, 4'd3, 4'd4, 4'd10, 4'd12},
    {7'b0100000, 4'd0, 4'd6, 4'd1, 4'd0, 4'd4, 4'd9,  4'd12},
    {7'b1100000, 4'd2, 4'd7, 4'd1, 4'd2, 4'd5, 4'd11, 4'd12},
    {7'b0010000, 4'd0, 4'd6, 4'd0, 4'd2, 4'd4, 4'd10, 4'd12},
    {7'b0000010, 4'd0, 4'd6, 4'd1, 4'd3, 4'd4, 4'd10, 4'd12},
    {7'b0001000, 4'd0, 4'd7, 4'd1, 4'd2, 4'd4, 4'd10, 4'd12},
    {7'b0101000, 4'd0, 4'd7, 4'd1, 4'd0, 4'd4, 4'd10, 4'd12},
    {7'b0101010, 4'd0, 4'd8, 4'd1, 4'd0, 4'd4, 4'd10, 4'd12},
    {7'b0000100, 4'd0, 4'd6, 4'd1, 4'd2, 4'd4, 4'd10, 4'd10},
    {7'b0000101, 4'd0, 4'd6, 4'd1, 4'd2, 4'd4, 4'd10, 4'd12},
    {7'b0100100, 4'd0, 4'd6, 4'd1, 4'd0, 4'd4, 4'd9,  4'd12},
    {7'b1100100, 4'd2, 4'd7, 4'd1, 4'd2, 4'd5, 4'd11, 4'd12},
    {7'b1001110, 4'd3, 4'd8, 4'd1, 4'd3, 4'd4, 4'd10, 4'd10},
    {7'b0000001, 4'd0, 4'd6, 4'd1, 4'd2, 4'd4, 4'd10, 4'd12}
  };

  function automatic string row_req(int i);
    case (i)
      0, 15:  return "R1";
      1:      return "R3";
      2, 6:   return "R7";
      3:      return "R4";
      4:      return "R5";
      5:      return "R6";
      7, 8, 9: return "R8";
      10, 14: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check_all(input logic [27:0] exp, input string req);
    logic [27:0] act;
    act = {sd, sc, ci, di, pd, pc, pr};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [6:0] c);
    @(negedge clk);
    ctl = c;
    update = 1'b1;
    @(negedge clk);
    update = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_all(VEC[0][27:0], "R1 reset");
    rst_ni = 1'b1;
    @(negedge clk);
    check_all(VEC[0][27:0], "R1 after release");

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][34:28]);
      check_all(VEC[i][27:0], row_req(i));
    end

    // R2: hold while update is low
    apply(7'b0000000);
    @(negedge clk);
    ctl = 7'b1100110;
    repeat (3) begin
      @(negedge clk);
      check_all(VEC[0][27:0], "R2 hold");
    end
    update = 1'b1;
    #1;
    check_all(VEC[0][27:0], "R2 before load edge");
    @(negedge clk);
    update = 1'b0;
    check_all({4'd3, 4'd8, 4'd1, 4'd3, 4'd5, 4'd11, 4'd12}, "R2 loaded");

    // R10: LOS arriving later takes effect at the next update only
    apply(7'b0000100);
    check_all(VEC[10][27:0], "R9 lt1 on");
    @(negedge clk);
    ctl = 7'b0000101;
    @(negedge clk);
    check_all(VEC[10][27:0], "R2 los held off");
    update = 1'b1;
    @(negedge clk);
    update = 1'b0;
    check_all(VEC[11][27:0], "R10 los override");

    // mid-run reset returns to R1 state
    apply(7'b1111110);
    #1 rst_ni = 1'b0;
    @(negedge clk);
    check_all(VEC[0][27:0], "R1 async reset");
    rst_ni = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule